// File: doc/BRIEF.md
# Backplane Bus Requester with Selectable Release Policies

This block sits on a board that shares a backplane with other masters. When local logic needs the backplane, the block raises one of four request lines and waits for the grant on the matching daisy-chain input. Once granted, it drives busy and tells local logic that it holds the bus. Grants on levels it is not waiting on are passed to the next board.

Software picks when a held bus is given up. The bus can go as soon as local use ends, or stay parked until another board requests it, until the arbiter signals bus clear, or until a tick-based timeout runs out. A separate option makes the block request the bus on its own whenever no other board is requesting. A release never cuts into a local transfer that is still running.

Top module: `bus_requester`

## Requirements
- R1: After reset, no request line, busy, local grant or timeout count is active.
- R2: From idle, when `need` is high, or `rnr_en` is high while `req_other` is all zero, the next cycle drives exactly bit `level_sel` of `req_out` high (levels 0 to 3). The level is captured at that point.
- R3: While requesting, `grant_in` high at the captured level makes `busy` and `granted` high from the next cycle, and `req_out` returns to zero in that same cycle.
- R4: `grant_out` copies `grant_in` on every level except the captured level. The captured level is copied only while idle and is forced low while requesting or holding.
- R5: With `policy` = 0 (release when done), a held bus is dropped the cycle after `need` is low.
- R6: With `policy` = 1 (release on request), a held bus is kept while `need` is low and is dropped the cycle after any bit of `req_other` is high.
- R7: With `policy` = 2 (release on bus clear), a held bus is kept until `bus_clr` is high, then dropped the next cycle.
- R8: With `policy` = 3 (release after timeout), `tick` pulses are counted from the grant. The count saturates at `tmo_limit`, and the bus is dropped the cycle after the count has reached `tmo_limit`.
- R9: While `need` is high, a held bus is never released, whatever the policy condition.
- R10: With `rnr_en` low, a set of `req_other` bits never starts a request. With `rnr_en` high, a request is started only while `req_other` is zero or `need` is high.
- R11: Once a request is raised, it stays raised until the grant arrives, even if `need` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| need | input | 1 | Local logic wants or is using the bus |
| level_sel | input | 2 | Request level to use |
| policy | input | 2 | Release policy: 0 done, 1 on request, 2 on bus clear, 3 timeout |
| rnr_en | input | 1 | Request whenever no other board requests |
| tmo_limit | input | TMO_W | Ticks before a timeout release |
| tick | input | 1 | Timebase pulse for the timeout |
| grant_in | input | 4 | Daisy-chain grant inputs, one per level |
| req_other | input | 4 | Request lines of other boards |
| bus_clr | input | 1 | Bus clear from the arbiter |
| req_out | output | 4 | Own request lines |
| grant_out | output | 4 | Daisy-chain grant outputs |
| busy | output | 1 | Bus busy driven by this board |
| granted | output | 1 | Local indication that the bus is held |

## Verification
Two events can land in the same cycle: a release condition (another board's request, bus clear or an expired timeout) and a local transfer that is still running. The bench makes them overlap by raising the release condition while `need` is still high. The per-cycle reference model then expects busy to stay up, and to fall only in the cycle after `need` drops. A second overlap is a grant on an unused level arriving while the block itself requests. Here the model expects the foreign grant to pass through and the own level to stay blocked.

// File: rtl/bus_requester.sv
module bus_requester #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             need,
  input  logic [1:0]       level_sel,
  input  logic [1:0]       policy,
  input  logic             rnr_en,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             tick,
  input  logic [3:0]       grant_in,
  input  logic [3:0]       req_other,
  input  logic             bus_clr,
  output logic [3:0]       req_out,
  output logic [3:0]       grant_out,
  output logic             busy,
  output logic             granted
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_OWN} st_t;

  st_t              st;
  logic [1:0]       lvl;
  logic [TMO_W-1:0] cnt;
  logic             want, rel_ok, expired, lvl_grant;

  assign want      = need | (rnr_en & ~|req_other);
  assign expired   = cnt >= tmo_limit;
  assign lvl_grant = grant_in[lvl];

  always_comb begin
    case (policy)
      2'd0:    rel_ok = 1'b1;
      2'd1:    rel_ok = |req_other;
      2'd2:    rel_ok = bus_clr;
      default: rel_ok = expired;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      lvl <= 2'd0;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (want) begin
          st  <= S_REQ;
          lvl <= level_sel;
        end
        S_REQ: if (lvl_grant) begin
          st  <= S_OWN;
          cnt <= '0;
        end
        default: begin
          if (!need && rel_ok) st <= S_IDLE;
          else if (tick && !expired) cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  for (genvar i = 0; i < 4; i++) begin : g_lvl
    assign req_out[i]   = (st == S_REQ) && (lvl == i);
    assign grant_out[i] = grant_in[i] && !((st != S_IDLE) && (lvl == i));
  end

  assign busy    = st == S_OWN;
  assign granted = st == S_OWN;

  assert_req_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_out));
  assert_grant_takes_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(req_out & grant_in)) |=> (busy && req_out == 4'd0));
  assert_no_busy_while_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && |req_out));
  assert_own_grant_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_out & req_out) == 4'd0);
  assert_done_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && policy == 2'd0 && !need) |=> !busy);
  assert_hold_in_use_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && need) |=> busy);
  assert_req_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_out && !(|(req_out & grant_in))) |=> $stable(req_out));
  assert_tmo_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && policy == 2'd3 && !expired) |=> busy);

endmodule

// File: tb/test_bus_requester.sv
module test_bus_requester;
  localparam int TMO_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic need = 1'b0, rnr_en = 1'b0, tick = 1'b0, bus_clr = 1'b0;
  logic [1:0] level_sel = 2'd0, policy = 2'd0;
  logic [TMO_W-1:0] tmo_limit = '0;
  logic [3:0] grant_in = 4'd0, req_other = 4'd0;
  logic [3:0] req_out, grant_out;
  logic busy, granted;

  int checks = 0, failures = 0, cycles = 0;
  int m_st = 0, m_lvl = 0, m_cnt = 0;

  always #2.5 clk = ~clk;

  bus_requester #(.TMO_W(TMO_W)) i_bus_requester (
    .clk(clk), .rst_n(rst_n), .need(need), .level_sel(level_sel),
    .policy(policy), .rnr_en(rnr_en), .tmo_limit(tmo_limit), .tick(tick),
    .grant_in(grant_in), .req_other(req_other), .bus_clr(bus_clr),
    .req_out(req_out), .grant_out(grant_out), .busy(busy), .granted(granted));

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_st = 0; m_lvl = 0; m_cnt = 0;
    end else if (m_st == 0) begin
      if (need || (rnr_en && req_other == 4'd0)) begin m_st = 1; m_lvl = level_sel; end
    end else if (m_st == 1) begin
      if (grant_in[m_lvl]) begin m_st = 2; m_cnt = 0; end
    end else begin
      bit go;
      case (policy)
        2'd0: go = 1;
        2'd1: go = req_other != 4'd0;
        2'd2: go = bus_clr;
        default: go = m_cnt >= int'(tmo_limit);
      endcase
      if (!need && go) m_st = 0;
      else if (tick && m_cnt < int'(tmo_limit)) m_cnt++;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    int eb, eo;
    @(negedge clk);
    eb = (m_st == 1) ? (1 << m_lvl) : 0;
    eo = 0;
    for (int i = 0; i < 4; i++)
      if (grant_in[i] && !(m_st != 0 && i == m_lvl)) eo |= (1 << i);
    check("R2 req_out", int'(req_out), eb);
    check("R3 busy", int'(busy), int'(m_st == 2));
    check("R3 granted", int'(granted), int'(m_st == 2));
    check("R4 grant_out", int'(grant_out), eo);
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  task automatic acquire(int lv);
    level_sel = 2'(lv); need = 1'b1;
    cyc();
    check("R2 level", int'(req_out), 1 << lv);
    grant_in = 4'(1 << lv);
    cyc();
    check("R3 grant->busy", int'(busy), 1);
    check("R3 req dropped", int'(req_out), 0);
    grant_in = 4'd0;
  endtask

  initial begin
    run(3);
    rst_n = 1'b1;
    cyc();
    check("R1 req_out", int'(req_out), 0);
    check("R1 busy", int'(busy), 0);

    // R4 pass-through while idle
    grant_in = 4'b1011; cyc();
    check("R4 idle pass", int'(grant_out), 11);
    grant_in = 4'd0;

    // R5 release when done, level 2, with foreign grant while requesting
    policy = 2'd0; level_sel = 2'd2; need = 1'b1; cyc();
    grant_in = 4'b0001; cyc();
    check("R4 foreign pass", int'(grant_out), 1);
    grant_in = 4'b0101; cyc();
    check("R4 own blocked", int'(grant_out[2]), 0);
    check("R3 busy", int'(busy), 1);
    grant_in = 4'd0; run(3);
    check("R9 held in use", int'(busy), 1);
    need = 1'b0; cyc();
    check("R5 released", int'(busy), 0);
    run(2);

    // R6 release on request, with R9 overlap
    policy = 2'd1; acquire(1);
    req_other = 4'b1000; run(2);
    check("R9 held despite request", int'(busy), 1);
    req_other = 4'd0; need = 1'b0; run(3);
    check("R6 parked", int'(busy), 1);
    req_other = 4'b0100; cyc();
    check("R6 released", int'(busy), 0);
    req_other = 4'd0; run(2);

    // R7 release on bus clear
    policy = 2'd2; acquire(0);
    need = 1'b0; req_other = 4'b0010; run(3);
    check("R7 parked", int'(busy), 1);
    req_other = 4'd0; bus_clr = 1'b1; cyc();
    check("R7 released", int'(busy), 0);
    bus_clr = 1'b0; run(2);

    // R8 timeout with limit 3
    policy = 2'd3; tmo_limit = 8'd3; acquire(3);
    need = 1'b0;
    for (int k = 0; k < 2; k++) begin tick = 1'b1; cyc(); tick = 1'b0; cyc(); end
    check("R8 not yet", int'(busy), 1);
    tick = 1'b1; cyc(); tick = 1'b0; cyc();
    check("R8 released", int'(busy), 0);
    run(2);

    // R8 zero limit releases at once once need falls
    tmo_limit = 8'd0; acquire(1);
    need = 1'b0; cyc();
    check("R8 zero limit", int'(busy), 0);
    run(2);

    // R10 request on no request
    policy = 2'd1; req_other = 4'b0001; run(3);
    check("R10 off no req", int'(req_out), 0);
    rnr_en = 1'b1; level_sel = 2'd2; run(2);
    check("R10 others busy", int'(req_out), 0);
    req_other = 4'd0; cyc();
    check("R10 request", int'(req_out), 4);
    grant_in = 4'b0100; cyc(); grant_in = 4'd0;
    check("R10 owns", int'(busy), 1);
    req_other = 4'b0001; cyc();
    check("R10 yield", int'(busy), 0);
    rnr_en = 1'b0; req_other = 4'd0; run(2);

    // R11 request held after need pulse
    policy = 2'd0; level_sel = 2'd1; need = 1'b1; cyc();
    need = 1'b0; run(4);
    check("R11 still requesting", int'(req_out), 2);
    grant_in = 4'b0010; cyc(); grant_in = 4'd0;
    check("R11 granted", int'(busy), 1);
    cyc();
    check("R11 done", int'(busy), 0);
    run(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    failures++; checks++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule